// File: doc/BRIEF.md
# External Interrupt Sense and Gating Controller

This block watches a bank of external interrupt pins and turns their activity into per-channel interrupt requests. Each pin is first brought into the clock domain through a two-stage synchronizer. It is then judged against a sense mode that software picks for that channel. The available modes are active-low level, active-high level, falling edge, rising edge, or either edge. A qualifying event sets a sticky detect bit. Software clears the bit by writing a one to it.

A per-CPU enable bank gates the detect bits onto one request output per channel. The enable bank has a set address and a clear address, so software never needs a read-modify-write to change a single channel. A read-only request view shows which channels are both detected and enabled. A monitor register shows the synchronized pin levels.

Software reaches all registers through a plain read/write port. Writes take effect on the clock edge where `bus_wr` is high. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd` is high. The port has no back-pressure: every access completes in one cycle, so it needs no valid/ready handshake. The pins and requests are plain level signals.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, all enable bits, detect bits and sense fields are zero, `irq_out` is all zero and `bus_rdata` is zero.
- R2: A read of offset 0x104 returns the synchronized pin levels. Bit n is pin n, as sampled two clock edges earlier. Bits above NUM_CH read zero.
- R3: Sense value 0x01 sets detect bit n on every cycle in which the synchronized pin n is low. Sense value 0x02 does the same while the pin is high.
- R4: Sense value 0x04 sets detect bit n on a synchronized high-to-low change of pin n. Value 0x08 sets it on a low-to-high change. Value 0x0C sets it on either change. A pin held steady sets nothing in these modes.
- R5: Any sense value other than 0x01, 0x02, 0x04, 0x08 or 0x0C, including zero, never sets the detect bit, whatever the pin does.
- R6: Detect status is at offset 0x100. Writing a 1 to bit n clears detect bit n. Bits written as 0 keep their value.
- R7: When an event for channel n and a clear of bit n occur in the same cycle, the detect bit stays set. As a result, in level modes a clear takes effect only once the pin is inactive.
- R8: A write to offset 0x08 sets the enable bits written as 1. A write to offset 0x04 clears the enable bits written as 1. In both cases, bits written as 0 are unchanged. A read of 0x04 returns the enable bits. A read of 0x08 returns zero.
- R9: A read of offset 0x00 returns detect AND enable. `irq_out[n]` equals bit n of that value.
- R10: The sense field of channel n is at offset 0x180 + 4*n and occupies bits [5:0]. Bits [31:6] read as zero. A write to one channel's field leaves all other channels unchanged.
- R11: Reads of unmapped offsets return zero. This includes sense-field offsets for channels at or above NUM_CH.
- R12: A pin change sampled at clock edge k is reflected in the detect bit and in `irq_out` after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NUM_CH | Raw external interrupt pins |
| irq_out | output | NUM_CH | Per-channel gated interrupt request |

## Verification
The main sweep covers every channel of a four-channel build with all 64 sense-field values. For each value it drives a fixed pin pattern of low hold, rise, high hold and fall, with a clear after each step. The expected detect bit is computed per step from the encoding. This separates the level modes from the edge modes, separates rising from falling, and confirms that invalid encodings stay silent. The clear made after each step shows whether the level is re-detected while the pin remains active. All sixteen pin patterns pass through the monitor register to confirm the synchronizer ordering. Enable set and clear writes with partial masks check that untouched channels keep their state and that the request output follows the gate.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W  = 9;
  localparam int DATA_W  = 32;
  localparam int SENSE_W = 6;

  localparam logic [ADDR_W-1:0] OFS_REQ    = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DET    = 9'h100;
  localparam logic [ADDR_W-1:0] OFS_MON    = 9'h104;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 9'h180;

  typedef enum logic [SENSE_W-1:0] {
    SNS_LOW  = 6'h01,
    SNS_HIGH = 6'h02,
    SNS_FALL = 6'h04,
    SNS_RISE = 6'h08,
    SNS_BOTH = 6'h0C
  } sense_e;

  typedef struct packed {
    logic lvl_lo;
    logic lvl_hi;
    logic edg_fall;
    logic edg_rise;
  } sense_sel_t;

  function automatic sense_sel_t sense_decode(input logic [SENSE_W-1:0] f);
    sense_sel_t s;
    s = '0;
    case (f)
      SNS_LOW:  s.lvl_lo   = 1'b1;
      SNS_HIGH: s.lvl_hi   = 1'b1;
      SNS_FALL: s.edg_fall = 1'b1;
      SNS_RISE: s.edg_rise = 1'b1;
      SNS_BOTH: begin
        s.edg_fall = 1'b1;
        s.edg_rise = 1'b1;
      end
      default:  s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_addr(input int ch);
    return OFS_CFG + ADDR_W'(4 * ch);
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= raw;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/eic_sense.sv
module eic_sense
  import eic_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_CH-1:0]         cur,
  input  logic [NUM_CH-1:0]         prv,
  input  logic [NUM_CH*SENSE_W-1:0] cfg_flat,
  output logic [NUM_CH-1:0]         evt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sense_sel_t sel;
    assign sel = sense_decode(cfg_flat[c*SENSE_W +: SENSE_W]);
    assign evt[c] = (sel.lvl_lo   & ~cur[c])
                  | (sel.lvl_hi   &  cur[c])
                  | (sel.edg_fall &  prv[c] & ~cur[c])
                  | (sel.edg_rise & ~prv[c] &  cur[c]);
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_CH-1:0]         mon,
  input  logic [NUM_CH-1:0]         evt,
  output logic [NUM_CH*SENSE_W-1:0] cfg_flat,
  output logic [NUM_CH-1:0]         det,
  output logic [NUM_CH-1:0]         en,
  output logic [NUM_CH-1:0]         req
);
  localparam int PAD_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] det_q, en_q;
  logic [NUM_CH-1:0] wmask, det_clr, en_set, en_clr;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign wmask   = bus_wdata[NUM_CH-1:0];
  assign det_clr = (bus_wr && bus_addr == OFS_DET)    ? wmask : '0;
  assign en_set  = (bus_wr && bus_addr == OFS_EN_SET) ? wmask : '0;
  assign en_clr  = (bus_wr && bus_addr == OFS_EN_CLR) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;
      en_q  <= '0;
    end else begin
      det_q <= (det_q & ~det_clr) | evt;
      en_q  <= (en_q | en_set) & ~en_clr;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    logic [SENSE_W-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else if (bus_wr && bus_addr == cfg_addr(c)) fld_q <= bus_wdata[SENSE_W-1:0];
    end
    assign cfg_flat[c*SENSE_W +: SENSE_W] = fld_q;
  end

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_CH-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_CH-1:0] = v;
    return r;
  endfunction

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_REQ:    rd_mux = widen(det_q & en_q);
      OFS_EN_CLR: rd_mux = widen(en_q);
      OFS_DET:    rd_mux = widen(det_q);
      OFS_MON:    rd_mux = widen(mon);
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (bus_addr == cfg_addr(c))
            rd_mux[SENSE_W-1:0] = cfg_flat[c*SENSE_W +: SENSE_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  if (PAD_W < 0) begin : g_bad_width
    initial $error("NUM_CH exceeds data width");
  end

  assign bus_rdata = rdata_q;
  assign det = det_q;
  assign en  = en_q;
  assign req = det_q & en_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [8:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] pin_in,
  output logic [NUM_CH-1:0] irq_out
);
  logic [NUM_CH-1:0]         cur_w, prv_w, evt_w, det_w, en_w;
  logic [NUM_CH*SENSE_W-1:0] cfg_w;

  eic_sync #(.W(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(cur_w), .prv(prv_w)
  );

  eic_sense #(.NUM_CH(NUM_CH)) u_sense (
    .cur(cur_w), .prv(prv_w), .cfg_flat(cfg_w), .evt(evt_w)
  );

  eic_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mon(cur_w), .evt(evt_w), .cfg_flat(cfg_w), .det(det_w), .en(en_w),
    .req(irq_out)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [8:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_CH-1:0] evt,
  input logic [NUM_CH-1:0] det,
  input logic [NUM_CH-1:0] en,
  input logic [NUM_CH-1:0] irq_out
);
  p_det_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DET) |=>
      ((det & $past(bus_wdata[NUM_CH-1:0]) & ~$past(evt)) == '0));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((det & $past(evt)) == $past(evt)));

  p_det_only_from_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |-> ((det & ~$past(det) & ~$past(evt)) == '0));

  p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=>
      ((en & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  p_en_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_CLR) |=> ((en & $past(bus_wdata[NUM_CH-1:0])) == '0));

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)) |=> $stable(en));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~en) == '0);
endmodule

bind ext_irq_ctrl eic_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt(evt_w), .det(det_w), .en(en_w), .irq_out(irq_out)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] irq_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit lvl(input int c, input bit v);
    return (c == 1 && !v) || (c == 2 && v);
  endfunction

  function automatic bit edg(input int c, input bit p, input bit v);
    return ((c == 4 || c == 12) && p && !v) || ((c == 8 || c == 12) && !p && v);
  endfunction

  function automatic string tag(input int c, input bit level_step);
    if (c == 1 || c == 2) return "R3";
    if (c == 4 || c == 8 || c == 12) return level_step ? "R7" : "R4";
    return "R5";
  endfunction

  task automatic step(input int ch, input int c, input bit p, input bit v, input bit carry);
    logic [31:0] d;
    bit e;
    pin_in[ch] = v;
    idle(4);
    e = carry | lvl(c, p) | lvl(c, v) | edg(c, p, v);
    rd(9'h100, d);
    chk(tag(c, 0), d, {31'b0, e} << ch);
    chk("R9", {28'b0, irq_out}, {31'b0, e} << ch);
    wr(9'h100, 32'hF);
    rd(9'h100, d);
    chk(lvl(c, v) ? "R7" : "R6", d, {31'b0, lvl(c, v)} << ch);
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    chk("R1", {28'b0, irq_out}, 0);
    chk("R1", bus_rdata, 0);
    rst_n = 1'b1;
    idle(2);
    rd(9'h100, d); chk("R1", d, 0);
    rd(9'h004, d); chk("R1", d, 0);
    rd(9'h180, d); chk("R1", d, 0);

    // R2: monitor register over all pin patterns
    for (int p = 0; p < 16; p++) begin
      pin_in = N'(p);
      idle(3);
      rd(9'h104, d);
      chk("R2", d, 32'(p));
    end
    pin_in = '0;
    idle(4);
    rd(9'h100, d); chk("R1", d, 0);

    // R10 / R11 field layout
    wr(9'h184, 32'hFFFF_FFC8);
    rd(9'h184, d); chk("R10", d, 32'h08);
    rd(9'h180, d); chk("R10", d, 0);
    rd(9'h188, d); chk("R10", d, 0);
    wr(9'h184, 32'h0);
    wr(9'h194, 32'h3F);
    rd(9'h194, d); chk("R11", d, 0);
    rd(9'h00C, d); chk("R11", d, 0);
    rd(9'h108, d); chk("R11", d, 0);
    rd(9'h008, d); chk("R11", d, 0);

    wr(9'h008, 32'hF);
    rd(9'h004, d); chk("R8", d, 32'hF);

    // Main sweep: every channel, every sense value
    for (int ch = 0; ch < N; ch++) begin
      for (int c = 0; c < 64; c++) begin
        wr(9'(9'h180 + 4 * ch), 32'(c));
        wr(9'h100, 32'hF);
        step(ch, c, 1'b0, 1'b0, 1'b0);
        step(ch, c, 1'b0, 1'b1, 1'b0);
        step(ch, c, 1'b1, 1'b1, 1'b0);
        step(ch, c, 1'b1, 1'b0, 1'b0);
      end
      wr(9'(9'h180 + 4 * ch), 32'h0);
      pin_in = '0;
      idle(4);
      wr(9'h100, 32'hF);
    end

    // R12: latency of a rising edge to irq_out
    wr(9'h180, 32'h08);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk); chk("R12", {28'b0, irq_out}, 0);
    @(negedge clk); chk("R12", {28'b0, irq_out}, 0);
    @(negedge clk); chk("R12", {28'b0, irq_out}, 1);

    // R8 / R9: enable gating with partial masks
    wr(9'h004, 32'h1);
    chk("R8", {28'b0, irq_out}, 0);
    rd(9'h004, d); chk("R8", d, 32'hE);
    rd(9'h000, d); chk("R9", d, 0);
    rd(9'h100, d); chk("R6", d, 1);
    wr(9'h008, 32'h0);
    rd(9'h004, d); chk("R8", d, 32'hE);
    wr(9'h004, 32'h0);
    rd(9'h004, d); chk("R8", d, 32'hE);
    wr(9'h008, 32'h1);
    chk("R9", {28'b0, irq_out}, 1);
    rd(9'h000, d); chk("R9", d, 1);
    wr(9'h100, 32'hE);
    rd(9'h100, d); chk("R6", d, 1);
    wr(9'h100, 32'h1);
    rd(9'h000, d); chk("R6", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule